// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block gives a small microcontroller core three memory-mapped bidirectional ports: a narrow 4-bit port and two 8-bit ports. Each port pin has an output data latch and a direction bit. The direction bit chooses between driving the latch value onto an external tristate pad and leaving the pad as a high-impedance input. The core addresses the ports through its register file. It can write a latch, load a direction register from its working register, and apply a single-bit set or clear. The set and clear operations work as read-modify-write on the whole port.

The core's instruction cycle has four phases, and the block takes the current phase as an input. Pins are sampled into a read register on the first phase. Latch and direction updates commit on the last phase. A port read always returns the sampled pin levels and never the latch. A bit operation therefore copies the levels seen on input-mode pins back into their latches, which can catch software unaware.

The third port can be built either as a real I/O port or as a plain storage register. An external reset and a power-on indication are both accepted. Each one is synchronised on release.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After either reset input is asserted, every direction bit is 1, so every pin_oe output is 0.
- R2: For a port pin whose direction bit is 0, the oe output is 1. For a pin whose direction bit is 1, the oe output is 0. The out output always shows the latch bit.
- R3: A direction load (`tris_ld`) in phase Q4 copies wdata into the direction register of the addressed port (05h narrow, 06h, 07h). A read of that address never returns the direction value.
- R4: A read of a port address returns the pin levels captured at the most recent Q1 edge, whatever the direction bits are. A pin that is driven high but held low externally reads 0.
- R5: The narrow port at 05h holds bits 3:0 only. Its read bits 7:4 are always 0. Writes to those bits, and bit operations with an index above 3, store nothing.
- R6: The phase input encodes Q1..Q4 as 0..3. Strobes take effect only in the cycle where phase is Q4. A strobe held only in Q1..Q3 leaves latches and direction unchanged.
- R7: A bit set or bit clear (bit_idx selects the bit) writes the Q1-sampled pins of the whole port into the latch, with the selected bit forced to 1 or 0. When several latch strobes are raised together, a plain write wins, then set, then clear.
- R8: Asserting only rst_n leaves the output latches unchanged. With CLR_ON_POR=1, asserting por_n clears them to 0.
- R9: With PC_IS_PORT=0, address 07h is plain storage. Writes and bit operations act on the stored byte, a read returns it, its pins are never driven, and a direction load to it has no effect.
- R10: Any address other than 05h..07h reads 0, and writes to it change no port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_n | input | 1 | Active-low power-on indication |
| phase | input | 2 | Current instruction phase, 0=Q1 .. 3=Q4 |
| addr | input | ADDR_W | Register address of the operation or read |
| wdata | input | DW | Write data or working-register value |
| wr_en | input | 1 | Write latch strobe |
| tris_ld | input | 1 | Direction load strobe |
| bset | input | 1 | Bit set strobe |
| bclr | input | 1 | Bit clear strobe |
| bit_idx | input | 3 | Bit selected by set or clear |
| rd_data | output | DW | Read data for addr |
| pa_in | input | PA_W | Narrow port pin levels |
| pa_out | output | PA_W | Narrow port output data |
| pa_oe | output | PA_W | Narrow port output enables |
| pb_in | input | PB_W | Port B pin levels |
| pb_out | output | PB_W | Port B output data |
| pb_oe | output | PB_W | Port B output enables |
| pc_in | input | PC_W | Port C pin levels |
| pc_out | output | PC_W | Port C output data |
| pc_oe | output | PC_W | Port C output enables |

## Verification
The bench builds two copies side by side with the same stimulus. One uses the defaults, where the third port is a real port and power-on clears the latches. The other sets PC_IS_PORT=0, so address 07h becomes storage. With both in one run, the port and storage behaviours of 07h can be compared cycle by cycle. The bench environment holds pull-ups on the top two bits of port B and can force single pins low. This exposes the two-step clear sequence, in which an input pin's pulled-up level lands in its latch, and also a driven-high pin that reads low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int W          = 8,
  parameter int DW         = 8,
  parameter bit PORT_MODE  = 1'b1,
  parameter bit CLR_ON_POR = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          q1,
  input  logic          q4,
  input  logic          sel,
  input  logic          wr_en,
  input  logic          tris_ld,
  input  logic          bset,
  input  logic          bclr,
  input  logic [2:0]    bit_idx,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [DW-1:0] rd_val
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] smp_q, smp_d;
  logic [W-1:0] src, bmask;
  logic         lat_en, dir_en, smp_en;
  logic         fresh_q;

  // read-modify-write source: live pins for a port, stored byte for storage
  assign src   = PORT_MODE ? smp_q : lat_q;
  assign bmask = {{(W-1){1'b0}}, 1'b1} << bit_idx;

  assign smp_en = q1 && rst_n;
  assign lat_en = q4 && sel && rst_n && (wr_en || bset || bclr);
  assign dir_en = q4 && sel && rst_n && tris_ld && PORT_MODE;

  always_comb begin
    lat_d = lat_q;
    if (wr_en)     lat_d = wdata[W-1:0];
    else if (bset) lat_d = src | bmask;
    else if (bclr) lat_d = src & ~bmask;
  end

  always_comb begin
    dir_d = wdata[W-1:0];
    smp_d = pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= '0;
    else if (smp_en) smp_q <= smp_d;
  end

  generate
    if (CLR_ON_POR) begin : g_lat_clr
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      lat_q <= '0;
        else if (lat_en) lat_q <= lat_d;
      end
    end else begin : g_lat_keep
      always_ff @(posedge clk) begin
        if (lat_en) lat_q <= lat_d;
      end
    end
  endgenerate

  generate
    if (PORT_MODE) begin : g_port
      assign pin_out = lat_q;
      assign pin_oe  = ~dir_q;
    end else begin : g_store
      assign pin_out = '0;
      assign pin_oe  = '0;
    end
  endgenerate

  assign rd_val = DW'(src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b1;
    else        fresh_q <= 1'b0;
  end

  // R1
  reset_dir_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> (pin_oe == '0));

  // R6
  latch_q4_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q4 |=> $stable(pin_out));

  generate
    if (PORT_MODE) begin : g_dir_chk
      // R3
      dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q4 && sel && tris_ld) |=> (pin_oe == ~$past(wdata[W-1:0])));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int ADDR_W     = 5,
  parameter int DW         = 8,
  parameter int PORT_BASE  = 5,
  parameter int PA_W       = 4,
  parameter int PB_W       = 8,
  parameter int PC_W       = 8,
  parameter bit PC_IS_PORT = 1'b1,
  parameter bit CLR_ON_POR = 1'b1,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [1:0]        phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              tris_ld,
  input  logic              bset,
  input  logic              bclr,
  input  logic [2:0]        bit_idx,
  output logic [DW-1:0]     rd_data,
  input  logic [PA_W-1:0]   pa_in,
  output logic [PA_W-1:0]   pa_out,
  output logic [PA_W-1:0]   pa_oe,
  input  logic [PB_W-1:0]   pb_in,
  output logic [PB_W-1:0]   pb_out,
  output logic [PB_W-1:0]   pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(PORT_BASE);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(PORT_BASE + 1);
  localparam logic [ADDR_W-1:0] ADDR_C = ADDR_W'(PORT_BASE + 2);

  logic sys_rst_n, por_sync_n;
  logic q1, q4;
  logic sel_a, sel_b, sel_c;
  logic [DW-1:0] rd_a, rd_b, rd_c;

  gpio_rst_sync #(.STAGES(SYNC_STG)) u_sys_sync (
    .clk(clk), .arst_n(rst_n && por_n), .srst_n(sys_rst_n)
  );
  gpio_rst_sync #(.STAGES(SYNC_STG)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_sync_n)
  );

  assign q1 = (phase_t'(phase) == PH_Q1);
  assign q4 = (phase_t'(phase) == PH_Q4);

  assign sel_a = (addr == ADDR_A);
  assign sel_b = (addr == ADDR_B);
  assign sel_c = (addr == ADDR_C);

  gpio_port_slice #(.W(PA_W), .DW(DW), .PORT_MODE(1'b1), .CLR_ON_POR(CLR_ON_POR)) u_port_a (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_sync_n), .q1(q1), .q4(q4), .sel(sel_a),
    .wr_en(wr_en), .tris_ld(tris_ld), .bset(bset), .bclr(bclr), .bit_idx(bit_idx),
    .wdata(wdata), .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a)
  );

  gpio_port_slice #(.W(PB_W), .DW(DW), .PORT_MODE(1'b1), .CLR_ON_POR(CLR_ON_POR)) u_port_b (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_sync_n), .q1(q1), .q4(q4), .sel(sel_b),
    .wr_en(wr_en), .tris_ld(tris_ld), .bset(bset), .bclr(bclr), .bit_idx(bit_idx),
    .wdata(wdata), .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b)
  );

  gpio_port_slice #(.W(PC_W), .DW(DW), .PORT_MODE(PC_IS_PORT), .CLR_ON_POR(CLR_ON_POR)) u_port_c (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_sync_n), .q1(q1), .q4(q4), .sel(sel_c),
    .wr_en(wr_en), .tris_ld(tris_ld), .bset(bset), .bclr(bclr), .bit_idx(bit_idx),
    .wdata(wdata), .pin_in(pc_in), .pin_out(pc_out), .pin_oe(pc_oe), .rd_val(rd_c)
  );

  always_comb begin
    rd_data = '0;
    if (sel_a)      rd_data = rd_a;
    else if (sel_b) rd_data = rd_b;
    else if (sel_c) rd_data = rd_c;
  end

  // R5
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (addr == ADDR_A) |-> (rd_data[DW-1:PA_W] == '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((addr < ADDR_A) || (addr > ADDR_C)) |-> (rd_data == '0));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst_n, por_n;
  logic [1:0] phase;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic       wr_en, tris_ld, bset, bclr;
  logic [2:0] bit_idx;

  logic [7:0] ext [3];
  logic [7:0] frc_en [3];
  logic [7:0] frc_val [3];

  logic [7:0] rd0, rd1;
  logic [3:0] pa_in0, pa_out0, pa_oe0, pa_in1, pa_out1, pa_oe1;
  logic [7:0] pb_in0, pb_out0, pb_oe0, pb_in1, pb_out1, pb_oe1;
  logic [7:0] pc_in0, pc_out0, pc_oe0, pc_in1, pc_out1, pc_oe1;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  function automatic logic [7:0] env_pin(logic [7:0] e, logic [7:0] fe, logic [7:0] fv,
                                         logic [7:0] oe, logic [7:0] out);
    logic [7:0] v;
    v = (oe & out) | (~oe & e);
    return (v & ~fe) | (fv & fe);
  endfunction

  logic [7:0] ea0, ea1, eb0, eb1, ec0, ec1;
  assign ea0 = env_pin(ext[0], frc_en[0], frc_val[0], {4'h0, pa_oe0}, {4'h0, pa_out0});
  assign ea1 = env_pin(ext[0], frc_en[0], frc_val[0], {4'h0, pa_oe1}, {4'h0, pa_out1});
  assign eb0 = env_pin(ext[1], frc_en[1], frc_val[1], pb_oe0, pb_out0);
  assign eb1 = env_pin(ext[1], frc_en[1], frc_val[1], pb_oe1, pb_out1);
  assign ec0 = env_pin(ext[2], frc_en[2], frc_val[2], pc_oe0, pc_out0);
  assign ec1 = env_pin(ext[2], frc_en[2], frc_val[2], pc_oe1, pc_out1);
  assign pa_in0 = ea0[3:0];
  assign pa_in1 = ea1[3:0];
  assign pb_in0 = eb0;
  assign pb_in1 = eb1;
  assign pc_in0 = ec0;
  assign pc_in1 = ec1;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .phase(phase), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .tris_ld(tris_ld), .bset(bset), .bclr(bclr), .bit_idx(bit_idx),
    .rd_data(rd0), .pa_in(pa_in0), .pa_out(pa_out0), .pa_oe(pa_oe0),
    .pb_in(pb_in0), .pb_out(pb_out0), .pb_oe(pb_oe0),
    .pc_in(pc_in0), .pc_out(pc_out0), .pc_oe(pc_oe0)
  );

  gpio_port_ctrl #(.PC_IS_PORT(1'b0)) u_gpio_store (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .phase(phase), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .tris_ld(tris_ld), .bset(bset), .bclr(bclr), .bit_idx(bit_idx),
    .rd_data(rd1), .pa_in(pa_in1), .pa_out(pa_out1), .pa_oe(pa_oe1),
    .pb_in(pb_in1), .pb_out(pb_out1), .pb_oe(pb_oe1),
    .pc_in(pc_in1), .pc_out(pc_out1), .pc_oe(pc_oe1)
  );

  // behavioural reference model
  logic [7:0] m_lat [2][3];
  logic [7:0] m_dir [2][3];
  logic [7:0] m_smp [2][3];
  bit m_s1 = 0, m_s2 = 0, m_p1 = 0, m_p2 = 0;

  function automatic logic [7:0] msk(int p);
    return (p == 0) ? 8'h0F : 8'hFF;
  endfunction
  function automatic bit is_store(int i, int p);
    return (i == 1) && (p == 2);
  endfunction
  function automatic logic [7:0] x_oe(int i, int p);
    return is_store(i, p) ? 8'h00 : (~m_dir[i][p] & msk(p));
  endfunction
  function automatic logic [7:0] x_out(int i, int p);
    return is_store(i, p) ? 8'h00 : (m_lat[i][p] & msk(p));
  endfunction
  function automatic logic [7:0] x_rd(int i);
    int p;
    if (addr < 5'h05 || addr > 5'h07) return 8'h00;
    p = int'(addr) - 5;
    if (is_store(i, p)) return m_lat[i][p];
    return m_smp[i][p] & msk(p);
  endfunction

  initial begin
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 3; p++) begin
        m_lat[i][p] = 8'h00; m_dir[i][p] = 8'hFF; m_smp[i][p] = 8'h00;
      end
  end

  task automatic chk(string what, int i, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s: actual %h expected %h at %0t", cur_req, i, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit act_sys, act_por;
    logic [7:0] pins, src, bm, nl, nd, ns;
    act_sys = !(rst_n && por_n) || !m_s2;
    act_por = !por_n || !m_p2;
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 3; p++) begin
        pins = env_pin(ext[p], frc_en[p], frc_val[p], x_oe(i, p), x_out(i, p)) & msk(p);
        src = is_store(i, p) ? m_lat[i][p] : m_smp[i][p];
        bm = (int'(bit_idx) < ((p == 0) ? 4 : 8)) ? (8'h01 << bit_idx) : 8'h00;
        nl = m_lat[i][p]; nd = m_dir[i][p]; ns = m_smp[i][p];
        if (act_sys) begin
          nd = 8'hFF; ns = 8'h00;
        end else begin
          if (phase == 2'd0) ns = pins;
          if (phase == 2'd3 && int'(addr) == p + 5) begin
            if (wr_en)     nl = wdata & msk(p);
            else if (bset) nl = (src | bm) & msk(p);
            else if (bclr) nl = (src & ~bm) & msk(p);
            if (tris_ld && !is_store(i, p)) nd = wdata | ~msk(p);
          end
        end
        if (act_por) nl = 8'h00;
        m_lat[i][p] = nl; m_dir[i][p] = nd; m_smp[i][p] = ns;
      end
    if (!(rst_n && por_n)) begin m_s1 = 0; m_s2 = 0; end
    else begin m_s2 = m_s1; m_s1 = 1; end
    if (!por_n) begin m_p1 = 0; m_p2 = 0; end
    else begin m_p2 = m_p1; m_p1 = 1; end
    #(CLK_P/4);
    chk("rd_data", 0, rd0, x_rd(0));
    chk("rd_data", 1, rd1, x_rd(1));
    chk("pa_out", 0, {4'h0, pa_out0}, x_out(0, 0));
    chk("pa_oe",  0, {4'h0, pa_oe0},  x_oe(0, 0));
    chk("pb_out", 0, pb_out0, x_out(0, 1));
    chk("pb_oe",  0, pb_oe0,  x_oe(0, 1));
    chk("pc_out", 0, pc_out0, x_out(0, 2));
    chk("pc_oe",  0, pc_oe0,  x_oe(0, 2));
    chk("pa_out", 1, {4'h0, pa_out1}, x_out(1, 0));
    chk("pa_oe",  1, {4'h0, pa_oe1},  x_oe(1, 0));
    chk("pb_out", 1, pb_out1, x_out(1, 1));
    chk("pb_oe",  1, pb_oe1,  x_oe(1, 1));
    chk("pc_out", 1, pc_out1, x_out(1, 2));
    chk("pc_oe",  1, pc_oe1,  x_oe(1, 2));
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  // one instruction cycle; strobes active in the phases flagged by phm
  task automatic op(logic [4:0] a, logic [7:0] d, bit w, bit t, bit s, bit c,
                    logic [2:0] b, logic [3:0] phm);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      phase = 2'(q); addr = a; wdata = d; bit_idx = b;
      wr_en = w && phm[q]; tris_ld = t && phm[q];
      bset = s && phm[q]; bclr = c && phm[q];
    end
  endtask

  task automatic rd(logic [4:0] a);
    op(a, 8'h00, 0, 0, 0, 0, 3'd0, 4'h0);
  endtask
  task automatic wr(logic [4:0] a, logic [7:0] d);
    op(a, d, 1, 0, 0, 0, 3'd0, 4'hF);
  endtask
  task automatic tris(logic [4:0] a, logic [7:0] d);
    op(a, d, 0, 1, 0, 0, 3'd0, 4'hF);
  endtask
  task automatic bs(logic [4:0] a, logic [2:0] b);
    op(a, 8'h00, 0, 0, 1, 0, b, 4'hF);
  endtask
  task automatic bc(logic [4:0] a, logic [2:0] b);
    op(a, 8'h00, 0, 0, 0, 1, b, 4'hF);
  endtask

  initial begin
    rst_n = 0; por_n = 0; phase = 0; addr = 0; wdata = 0;
    wr_en = 0; tris_ld = 0; bset = 0; bclr = 0; bit_idx = 0;
    ext[0] = 8'h09; ext[1] = 8'hC3; ext[2] = 8'h5A;
    for (int p = 0; p < 3; p++) begin frc_en[p] = 0; frc_val[p] = 0; end

    // R1 R8: power-on reset, all pins inputs, latches cleared
    cur_req = "R1";
    repeat (2) rd(5'h06);
    @(negedge clk); rst_n = 1; por_n = 1;
    repeat (2) rd(5'h06);

    // R4: reads return pin levels with everything as input
    cur_req = "R4";
    rd(5'h05); rd(5'h06); rd(5'h07);

    // R2 R3: direction loads and latch writes
    cur_req = "R3";
    tris(5'h05, 8'hF0);
    wr(5'h05, 8'h06);
    rd(5'h05);
    cur_req = "R2";
    tris(5'h07, 8'h0F);
    wr(5'h07, 8'hA5);
    rd(5'h07);

    // R7: two-step clear on port B, bits 7:4 inputs with pull-ups on 7:6
    cur_req = "R7";
    tris(5'h06, 8'hF0);
    wr(5'h06, 8'h0A);
    bc(5'h06, 3'd7);
    bc(5'h06, 3'd6);
    tris(5'h06, 8'h3F);
    rd(5'h06);
    bs(5'h06, 3'd0);
    op(5'h06, 8'h81, 1, 0, 1, 1, 3'd2, 4'hF);
    op(5'h06, 8'h00, 0, 0, 1, 1, 3'd4, 4'hF);
    rd(5'h06);

    // R4: a driven-high pin held low externally reads low
    cur_req = "R4";
    tris(5'h06, 8'h00);
    wr(5'h06, 8'hFF);
    frc_en[1] = 8'h01; frc_val[1] = 8'h00;
    rd(5'h06);
    wr(5'h06, 8'h3C);
    rd(5'h06);
    frc_en[1] = 8'h00;
    rd(5'h06);

    // R5: narrow port upper bits
    cur_req = "R5";
    tris(5'h05, 8'h00);
    wr(5'h05, 8'hFF);
    rd(5'h05);
    bc(5'h05, 3'd6);
    bc(5'h05, 3'd1);
    rd(5'h05);

    // R6: strobes outside Q4 ignored
    cur_req = "R6";
    op(5'h06, 8'h11, 1, 0, 0, 0, 3'd0, 4'h7);
    op(5'h06, 8'hFF, 0, 1, 0, 0, 3'd0, 4'h7);
    op(5'h05, 8'h00, 0, 0, 1, 0, 3'd3, 4'h3);
    rd(5'h06);

    // R9: address 07h as storage in the second copy
    cur_req = "R9";
    wr(5'h07, 8'h96);
    bs(5'h07, 3'd0);
    bc(5'h07, 3'd7);
    tris(5'h07, 8'h00);
    rd(5'h07);

    // R10: unmapped addresses
    cur_req = "R10";
    wr(5'h04, 8'h00);
    wr(5'h08, 8'h00);
    rd(5'h04); rd(5'h1F); rd(5'h00);

    // R8: external reset only keeps latches; power-on clears them
    cur_req = "R8";
    tris(5'h06, 8'h00);
    wr(5'h06, 8'h5A);
    @(negedge clk); rst_n = 0;
    rd(5'h06);
    @(negedge clk); rst_n = 1;
    rd(5'h06); rd(5'h06);
    tris(5'h06, 8'h00);
    rd(5'h06);
    @(negedge clk); por_n = 0;
    rd(5'h06);
    @(negedge clk); por_n = 1;
    rd(5'h06); rd(5'h06);
    cur_req = "R1";
    rd(5'h05);

    summary();
  end
endmodule